// File: doc/BRIEF.md
# Day and Time-of-Day Real-Time Clock Core

This block keeps wall-clock time as a count of seconds within the current day plus a count of whole days. A fast enable input, standing in for a divided crystal clock, is divided down by an internal prescaler to produce one second tick. The seconds count wraps at the end of the day and carries into the day count. Software reads and writes the time through a simple synchronous register bus. The seconds value is split across a low byte register and a nine-bit upper register, and the day count has a register of its own.

A second register set holds an alarm time. The block raises an alarm event when the full running time first matches it. A separate update event is raised on every second tick. Each event has a sticky status bit that is cleared by writing a one to it, and an enable bit. The single interrupt output is active while any enabled status bit is set.

Reads of the low byte take a snapshot of the upper field and the day, so that a multi-register read cannot tear across a rollover. Writing the low byte resets the prescaler, so a set sequence ending in the low byte makes the new time take effect at a well-defined instant.

Top module: `tod_rtc_core`

## Requirements
- R1: After reset every register (addresses 0 to 7) reads zero and `irq_o` is low; both interrupt enables are off.
- R2: The prescaler produces one second tick for every PRESC_DIV cycles with `sub_tick_i` high, and each tick adds one to the seconds-of-day count.
- R3: On a tick at second 86399 the seconds count returns to 0 and the day count (15 bits) increments; day 32767 wraps to 0.
- R4: Address 0 reads and writes seconds bits 7:0, address 1 reads and writes seconds bits 16:8 in data bits 8:0, address 2 reads and writes the day in data bits 14:0; data bits above each field read as zero and are ignored on write. Addresses 3, 4 and 5 hold the alarm in the same layout.
- R5: Any write to address 0 clears the prescaler, so the next tick comes after exactly PRESC_DIV further `sub_tick_i` cycles.
- R6: A read of address 0 snapshots the upper seconds field and the day; later reads of addresses 1 and 2 return that snapshot until the next read of address 0.
- R7: A write to address 0 or 1 that would make the seconds count 86400 or more sets it to 86399.
- R8: After writing the day, then address 1, then address 0, the clock holds exactly the written time; after address 0 is written with zero, the upper seconds field stays unchanged for at least 255 ticks.
- R9: Status bit 0 (address 6) is set in the cycle after the running day and seconds change from not matching to matching the alarm registers.
- R10: Status bit 1 is set by every second tick.
- R11: Status bits stay set until a one is written to them at address 6; a new event in the same cycle as the clearing write leaves the bit set.
- R12: `irq_o` is high exactly when some status bit is set whose enable bit (address 7, bit 0 alarm, bit 1 update) is one.
- R13: When a tick coincides with a write to address 1 or 2, the written value is taken, the tick does not advance the time, and status bit 1 is still set; with a write to address 0 no tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| sub_tick_i | input | 1 | Prescaler enable, PRESC_DIV pulses per second |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (drives the snapshot) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt, OR of enabled status bits |

## Verification
Two collisions matter here: a second tick landing in the same cycle as a bus write to a time field, and an event setting a status bit in the same cycle that software writes one to clear it. The bench provokes both by raising `sub_tick_i` during the write cycle exactly when the prescaler is one step from expiry, both in directed cases and at random. It judges them against a bench model that applies the write, suppresses the advance and lets the set win over the clear, then reads the time and status back over the bus.

// File: rtl/rtc_pkg.sv
// Shared definitions for the real-time clock core.
// Assumes a three-bit register address space.
package rtc_pkg;
    typedef enum logic [2:0] {
        RA_TIME_LO = 3'd0,
        RA_TIME_HI = 3'd1,
        RA_DAY     = 3'd2,
        RA_ALM_LO  = 3'd3,
        RA_ALM_HI  = 3'd4,
        RA_ALM_DAY = 3'd5,
        RA_STATUS  = 3'd6,
        RA_ENABLE  = 3'd7
    } rtc_addr_e;

    localparam int IRQ_ALARM  = 0;
    localparam int IRQ_UPDATE = 1;
    localparam int IRQ_NUM    = 2;
endpackage

// File: rtl/rtc_prescaler.sv
// Divides the sub-second enable down to a one-second tick.
// Assumes DIV >= 2. A clear has priority and suppresses the tick.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic sub_tick_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Tick when the last sub-second step arrives, unless being cleared.
    assign tick_o = sub_tick_i && !clr_i && (cnt_q == LAST);

    // Sub-second counter: cleared by reset or clear, wraps at DIV.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || clr_i) begin
            cnt_q <= '0;
        end else if (sub_tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_timebase.sv
// Seconds-of-day and day counters with bus write access.
// Assumes the seconds field splits into LO_W low bits and the rest.
// A bus write to any time field takes priority over a coincident tick.
module rtc_timebase #(
    parameter int SOD_W     = 17,
    parameter int LO_W      = 8,
    parameter int DAY_W     = 15,
    parameter int SOD_LIMIT = 86400,
    parameter int DATA_W    = 16
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              tick_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic              wr_day_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [SOD_W-1:0]  sod_o,
    output logic [DAY_W-1:0]  day_o
);
    localparam int HI_W = SOD_W - LO_W;
    localparam logic [SOD_W-1:0] SOD_LAST = SOD_W'(SOD_LIMIT - 1);

    logic [SOD_W-1:0] sod_q;
    logic [DAY_W-1:0] day_q;
    logic             advance;
    logic             day_carry;
    logic [SOD_W-1:0] cand_lo;
    logic [SOD_W-1:0] cand_hi;

    // Limit a written seconds value to the last second of the day.
    function automatic logic [SOD_W-1:0] clamp_sod(input logic [SOD_W-1:0] v);
        return (v > SOD_LAST) ? SOD_LAST : v;
    endfunction

    // Candidate seconds values for a write to either half.
    always_comb begin
        cand_lo = {sod_q[SOD_W-1:LO_W], wdata_i[LO_W-1:0]};
        cand_hi = {wdata_i[HI_W-1:0], sod_q[LO_W-1:0]};
    end

    assign advance   = tick_i && !(wr_lo_i || wr_hi_i || wr_day_i);
    assign day_carry = advance && (sod_q == SOD_LAST);

    // Seconds register: write, else count with end-of-day wrap.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            sod_q <= '0;
        end else if (wr_lo_i) begin
            sod_q <= clamp_sod(cand_lo);
        end else if (wr_hi_i) begin
            sod_q <= clamp_sod(cand_hi);
        end else if (advance) begin
            sod_q <= (sod_q == SOD_LAST) ? '0 : sod_q + 1'b1;
        end
    end

    // Day register: write, else increment on the end-of-day carry.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            day_q <= '0;
        end else if (wr_day_i) begin
            day_q <= wdata_i[DAY_W-1:0];
        end else if (day_carry) begin
            day_q <= day_q + 1'b1;
        end
    end

    assign sod_o = sod_q;
    assign day_o = day_q;
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Sticky interrupt status with write-one-to-clear and per-source enable.
// Assumes one set pulse per source; a set beats a clear in the same cycle.
module rtc_irq_ctrl #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [N-1:0] set_i,
    input  logic         stat_wr_i,
    input  logic         en_wr_i,
    input  logic [N-1:0] wbits_i,
    output logic [N-1:0] stat_o,
    output logic [N-1:0] en_o,
    output logic         irq_o
);
    logic [N-1:0] stat_q;
    logic [N-1:0] en_q;
    logic [N-1:0] pend;

    for (genvar g = 0; g < N; g++) begin : g_src
        // One status bit: set by its event, cleared by a one written to it.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i) begin
                stat_q[g] <= 1'b0;
            end else if (set_i[g]) begin
                stat_q[g] <= 1'b1;
            end else if (stat_wr_i && wbits_i[g]) begin
                stat_q[g] <= 1'b0;
            end
        end
        assign pend[g] = stat_q[g] & en_q[g];
    end

    // Enable bits: loaded by a bus write, all off after reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            en_q <= '0;
        end else if (en_wr_i) begin
            en_q <= wbits_i;
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign irq_o  = |pend;
endmodule

// File: rtl/tod_rtc_core.sv
// Top of the real-time clock core: register decode, alarm compare,
// read snapshot and read mux. Assumes single-cycle bus strobes and
// that rd_en_i is raised once per register read.
module tod_rtc_core #(
    parameter int PRESC_DIV = 32768,
    parameter int DATA_W    = 16,
    parameter int SOD_W     = 17,
    parameter int LO_W      = 8,
    parameter int DAY_W     = 15,
    parameter int SOD_LIMIT = 86400
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              sub_tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    import rtc_pkg::*;

    localparam int HI_W = SOD_W - LO_W;

    rtc_addr_e            addr;
    logic                 wr_tlo, wr_thi, wr_day;
    logic                 wr_alo, wr_ahi, wr_aday;
    logic                 wr_stat, wr_en;
    logic                 sec_tick;
    logic [SOD_W-1:0]     sod;
    logic [DAY_W-1:0]     day;
    logic [SOD_W-1:0]     alm_sod_q;
    logic [DAY_W-1:0]     alm_day_q;
    logic [HI_W-1:0]      snap_hi_q;
    logic [DAY_W-1:0]     snap_day_q;
    logic                 alm_hit;
    logic                 hit_q;
    logic [IRQ_NUM-1:0]   irq_set;
    logic [IRQ_NUM-1:0]   stat;
    logic [IRQ_NUM-1:0]   en;

    assign addr = rtc_addr_e'(addr_i);

    // Write strobe decode, one per register.
    always_comb begin
        wr_tlo  = wr_en_i && (addr == RA_TIME_LO);
        wr_thi  = wr_en_i && (addr == RA_TIME_HI);
        wr_day  = wr_en_i && (addr == RA_DAY);
        wr_alo  = wr_en_i && (addr == RA_ALM_LO);
        wr_ahi  = wr_en_i && (addr == RA_ALM_HI);
        wr_aday = wr_en_i && (addr == RA_ALM_DAY);
        wr_stat = wr_en_i && (addr == RA_STATUS);
        wr_en   = wr_en_i && (addr == RA_ENABLE);
    end

    rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .sub_tick_i (sub_tick_i),
        .clr_i      (wr_tlo),
        .tick_o     (sec_tick)
    );

    rtc_timebase #(
        .SOD_W(SOD_W), .LO_W(LO_W), .DAY_W(DAY_W),
        .SOD_LIMIT(SOD_LIMIT), .DATA_W(DATA_W)
    ) u_time (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .tick_i   (sec_tick),
        .wr_lo_i  (wr_tlo),
        .wr_hi_i  (wr_thi),
        .wr_day_i (wr_day),
        .wdata_i  (wdata_i),
        .sod_o    (sod),
        .day_o    (day)
    );

    // Alarm registers: each bus write loads its own field.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            alm_sod_q <= '0;
            alm_day_q <= '0;
        end else begin
            if (wr_alo)  alm_sod_q[LO_W-1:0]     <= wdata_i[LO_W-1:0];
            if (wr_ahi)  alm_sod_q[SOD_W-1:LO_W] <= wdata_i[HI_W-1:0];
            if (wr_aday) alm_day_q               <= wdata_i[DAY_W-1:0];
        end
    end

    assign alm_hit = (sod == alm_sod_q) && (day == alm_day_q);

    // Match history; starts high so the reset match does not fire.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) hit_q <= 1'b1;
        else          hit_q <= alm_hit;
    end

    always_comb begin
        irq_set             = '0;
        irq_set[IRQ_ALARM]  = alm_hit && !hit_q;
        irq_set[IRQ_UPDATE] = sec_tick;
    end

    rtc_irq_ctrl #(.N(IRQ_NUM)) u_irq (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .set_i     (irq_set),
        .stat_wr_i (wr_stat),
        .en_wr_i   (wr_en),
        .wbits_i   (wdata_i[IRQ_NUM-1:0]),
        .stat_o    (stat),
        .en_o      (en),
        .irq_o     (irq_o)
    );

    // Snapshot of upper seconds and day, taken on a low-byte read.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            snap_hi_q  <= '0;
            snap_day_q <= '0;
        end else if (rd_en_i && (addr == RA_TIME_LO)) begin
            snap_hi_q  <= sod[SOD_W-1:LO_W];
            snap_day_q <= day;
        end
    end

    // Read data mux with zero-filled upper bits.
    always_comb begin
        rdata_o = '0;
        case (addr)
            RA_TIME_LO: rdata_o = DATA_W'(sod[LO_W-1:0]);
            RA_TIME_HI: rdata_o = DATA_W'(snap_hi_q);
            RA_DAY:     rdata_o = DATA_W'(snap_day_q);
            RA_ALM_LO:  rdata_o = DATA_W'(alm_sod_q[LO_W-1:0]);
            RA_ALM_HI:  rdata_o = DATA_W'(alm_sod_q[SOD_W-1:LO_W]);
            RA_ALM_DAY: rdata_o = DATA_W'(alm_day_q);
            RA_STATUS:  rdata_o = DATA_W'(stat);
            RA_ENABLE:  rdata_o = DATA_W'(en);
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/rtc_core_chk.sv
// Assertion checker for the real-time clock core, bound to the top.
// Assumes the internal tick, write strobes and counters are visible.
module rtc_core_chk #(
    parameter int SOD_W     = 17,
    parameter int DAY_W     = 15,
    parameter int SOD_LIMIT = 86400
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic             sec_tick,
    input logic             time_wr,
    input logic             stat_wr,
    input logic [SOD_W-1:0] sod,
    input logic [DAY_W-1:0] day,
    input logic [1:0]       stat,
    input logic [1:0]       en,
    input logic             irq_o
);
    localparam logic [SOD_W-1:0] LAST = SOD_W'(SOD_LIMIT - 1);

    // R3
    sod_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sod <= LAST);

    // R2
    sec_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (sec_tick && !time_wr && sod != LAST) |=> (sod == $past(sod) + 1'b1));

    // R3
    day_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (sec_tick && !time_wr && sod == LAST) |=>
            (sod == '0 && day == DAY_W'($past(day) + 1'b1)));

    // R13
    day_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!sec_tick && !time_wr) |=> $stable(day));

    // R10
    update_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sec_tick |=> stat[1]);

    // R11
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(stat[1]) |-> $past(stat_wr));

    // R12
    irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        irq_o |-> ((stat & en) != 2'b00));

    // R12
    irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (en == 2'b00) |-> !irq_o);
endmodule

bind tod_rtc_core rtc_core_chk #(
    .SOD_W(SOD_W), .DAY_W(DAY_W), .SOD_LIMIT(SOD_LIMIT)
) u_chk (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .sec_tick (sec_tick),
    .time_wr  (wr_tlo || wr_thi || wr_day),
    .stat_wr  (wr_stat),
    .sod      (sod),
    .day      (day),
    .stat     (stat),
    .en       (en),
    .irq_o    (irq_o)
);

// File: tb/tod_rtc_core_bench.sv
module tod_rtc_core_bench;
    localparam int DIV = 4;

    logic        clk_i = 1'b0;
    logic        rst_n_i = 1'b0;
    logic        sub_tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [2:0]  addr_i = 3'd0;
    logic [15:0] wdata_i = 16'd0;
    logic [15:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;

    // Bench model of the requirements
    int       m_sod, m_day, m_pc, m_asod, m_aday, m_shi, m_sday;
    bit [1:0] m_stat, m_en;
    bit       m_prev;

    always #2 clk_i = ~clk_i;

    tod_rtc_core #(.PRESC_DIV(DIV)) u_tod_rtc_core (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .sub_tick_i(sub_tick_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int clampv(int v);
        return (v >= 86400) ? 86399 : v;
    endfunction

    task automatic m_advance();
        if (m_sod == 86399) begin
            m_sod = 0;
            m_day = (m_day + 1) & 32'h7FFF;
        end else begin
            m_sod++;
        end
    endtask

    task automatic m_alarm();
        bit hit;
        hit = (m_sod == m_asod) && (m_day == m_aday);
        if (hit && !m_prev) m_stat[0] = 1'b1;
        m_prev = hit;
    endtask

    task automatic m_sub(bit wr_lo);
        bit tick;
        tick = 1'b0;
        if (wr_lo) m_pc = 0;
        else begin
            m_pc++;
            if (m_pc == DIV) begin m_pc = 0; tick = 1'b1; end
        end
        if (tick) m_stat[1] = 1'b1;
        if (tick && !wr_lo) m_advance();
    endtask

    // Pulse sub_tick_i for n cycles.
    task automatic run_sub(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            sub_tick_i = 1'b1;
            m_sub(1'b0);
            m_alarm();
        end
        @(negedge clk_i);
        sub_tick_i = 1'b0;
    endtask

    // Bus write, optionally with a coincident sub-tick.
    task automatic bus_wr(int a, int d, bit sub);
        bit tick;
        @(negedge clk_i);
        wr_en_i = 1'b1; addr_i = 3'(a); wdata_i = 16'(d); sub_tick_i = sub;
        tick = 1'b0;
        if (a == 0) m_pc = 0;
        else if (sub) begin
            m_pc++;
            if (m_pc == DIV) begin m_pc = 0; tick = 1'b1; end
        end
        case (a)
            0: m_sod = clampv((m_sod & 32'h1FF00) | (d & 255));
            1: m_sod = clampv(((d & 32'h1FF) << 8) | (m_sod & 255));
            2: m_day = d & 32'h7FFF;
            3: m_asod = (m_asod & 32'h1FF00) | (d & 255);
            4: m_asod = ((d & 32'h1FF) << 8) | (m_asod & 255);
            5: m_aday = d & 32'h7FFF;
            6: m_stat = m_stat & ~2'(d);
            default: m_en = 2'(d);
        endcase
        if (tick) begin
            m_stat[1] = 1'b1;
            if (a > 2) m_advance();
        end
        m_alarm();
        @(negedge clk_i);
        wr_en_i = 1'b0; sub_tick_i = 1'b0;
    endtask

    task automatic bus_rd(int a, output int v);
        @(negedge clk_i);
        rd_en_i = 1'b1; addr_i = 3'(a);
        #1 v = int'(rdata_o);
        @(negedge clk_i);
        rd_en_i = 1'b0;
    endtask

    function automatic int m_read(int a);
        case (a)
            0: return m_sod & 255;
            1: return m_shi;
            2: return m_sday;
            3: return m_asod & 255;
            4: return m_asod >> 8;
            5: return m_aday;
            6: return int'(m_stat);
            default: return int'(m_en);
        endcase
    endfunction

    task automatic rd_chk(string req, int a);
        int v, e;
        e = m_read(a);
        bus_rd(a, v);
        if (a == 0) begin m_shi = m_sod >> 8; m_sday = m_day; end
        check(req, v, e);
    endtask

    task automatic irq_chk(string req);
        #1 check(req, int'(irq_o), int'((m_stat & m_en) != 2'b00));
    endtask

    task automatic rd_time(string req);
        rd_chk(req, 0); rd_chk(req, 1); rd_chk(req, 2);
    endtask

    // Watchdog
    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v, hi0;
        m_sod = 0; m_day = 0; m_pc = 0; m_asod = 0; m_aday = 0;
        m_shi = 0; m_sday = 0; m_stat = 0; m_en = 0; m_prev = 1'b1;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk_i);
        rst_n_i = 1'b1;

        // R1: all registers zero after reset
        for (int a = 0; a < 8; a++) rd_chk("R1", a);
        irq_chk("R1");

        // R2: one tick per DIV sub-ticks
        run_sub(DIV - 1);
        rd_chk("R2", 0);
        check("R2 no tick yet", m_sod, 0);
        run_sub(1);
        rd_chk("R2", 0);
        check("R2 one second", m_sod, 1);

        // R5: low-byte write clears prescaler
        run_sub(2);
        bus_wr(0, 16'h0010, 1'b0);
        run_sub(DIV - 1);
        rd_chk("R5", 0);
        check("R5 model", m_sod, 16);
        run_sub(1);
        rd_chk("R5", 0);

        // R4: field widths, upper bits ignored
        bus_wr(2, 16'hFFFF, 1'b0);
        bus_wr(1, 16'hFE01, 1'b0);
        rd_time("R4");
        bus_wr(3, 16'hABCD, 1'b0);
        bus_wr(4, 16'hFFFF, 1'b0);
        bus_wr(5, 16'h8001, 1'b0);
        rd_chk("R4", 3); rd_chk("R4", 4); rd_chk("R4", 5);

        // R7: clamp on high write
        bus_wr(1, 16'h01FF, 1'b0);
        rd_time("R7");
        check("R7 model", m_sod, 86399);

        // R3: end-of-day wrap and day counter wrap (day is 0x7FFF)
        run_sub(DIV);
        rd_time("R3");
        check("R3 day wrap", m_day, 0);

        // R8: DAY, HI, LO sequence and 255-tick hold after LO=0
        bus_wr(2, 100, 1'b0);
        bus_wr(1, 16'h00A5, 1'b0);
        bus_wr(0, 16'h003C, 1'b0);
        rd_time("R8");
        bus_wr(0, 0, 1'b0);
        rd_chk("R8", 0);
        hi0 = m_shi;
        run_sub(255 * DIV);
        rd_chk("R8", 0);
        rd_chk("R8", 1);
        check("R8 hold", m_shi, hi0);

        // R6: snapshot survives rollover
        bus_wr(2, 5, 1'b0);
        bus_wr(1, 16'h0151, 1'b0);
        bus_wr(0, 16'h007F, 1'b0);
        rd_chk("R6", 0);
        run_sub(DIV);
        bus_rd(1, v); check("R6 hi snapshot", v, 16'h151);
        bus_rd(2, v); check("R6 day snapshot", v, 5);
        rd_time("R6");

        // R9 and R12: alarm fires and drives irq when enabled
        bus_wr(6, 3, 1'b0);
        bus_wr(7, 1, 1'b0);
        bus_wr(5, m_day, 1'b0);
        bus_wr(4, (m_sod + 3) >> 8, 1'b0);
        bus_wr(3, (m_sod + 3) & 255, 1'b0);
        irq_chk("R12");
        run_sub(3 * DIV);
        rd_chk("R9", 6);
        check("R9 alarm bit", int'(m_stat[0]), 1);
        irq_chk("R12");
        bus_wr(6, 1, 1'b0);
        rd_chk("R11", 6);
        irq_chk("R12");

        // R10 and R11: update status, W1C colliding with a tick
        bus_wr(7, 2, 1'b0);
        run_sub(DIV);
        rd_chk("R10", 6);
        irq_chk("R12");
        run_sub(DIV - 1);
        bus_wr(6, 2, 1'b1);
        rd_chk("R11", 6);
        check("R11 set wins", int'(m_stat[1]), 1);

        // R13: tick collides with time writes
        bus_wr(6, 3, 1'b0);
        run_sub(DIV - 1);
        bus_wr(1, 16'h0002, 1'b1);
        rd_time("R13");
        rd_chk("R13", 6);
        run_sub(DIV - 1);
        bus_wr(2, 16'h0033, 1'b1);
        rd_time("R13");
        bus_wr(6, 3, 1'b0);
        run_sub(DIV - 1);
        bus_wr(0, 16'h0044, 1'b1);
        rd_time("R13");
        rd_chk("R13", 6);

        // Random mix, R2 R4 R11 R12 R13
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: bus_wr(int'($urandom % 8), int'($urandom % 65536),
                          bit'($urandom % 2));
                1: rd_chk("R4 random", int'($urandom % 8));
                2: run_sub(int'($urandom % 12));
                default: irq_chk("R12 random");
            endcase
        end
        rd_time("R2 random");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule